// File: doc/BRIEF.md
# Folded Symmetric Decimating FIR Filter

This block low-pass filters and decimates an audio sample stream whose sample rate is low compared to the system clock. Incoming samples go into a circular buffer that always holds the newest 768 samples. The filter has 768 taps and they are symmetric about the centre, so tap k and tap 767-k share one coefficient. That symmetry lets the block fold each such pair into one operation. It adds the two samples first and multiplies the sum once by their shared coefficient. One of these multiply-accumulates completes on every clock.

A full filter evaluation therefore takes 384 clocks, and the block produces exactly one output sample per 384 system clocks. The coefficient store sits outside the block and holds only the 384 unique taps. It is addressed by the pair index and answers within the same cycle. At the end of each period the sum is rounded, shifted down, clamped to the output width and presented with a one-cycle valid pulse.

Input samples normally arrive once every twelve clocks. The block accepts them at any rate up to one per clock, even in the middle of an evaluation, without disturbing the evaluation in progress.

Top module: `sym_decim_fir`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is 0. Every buffer entry reads as zero and the write position is slot 0.
- R2: In every cycle with `in_valid` high, `in_data` is stored as the newest sample. An evaluation sees the 768 most recently accepted samples. Positions that no sample has filled since reset count as zero.
- R3: Evaluation periods are 384 cycles long. The first period starts in the first cycle after reset release, counted as cycle 0. `out_valid` is high for exactly one cycle, namely cycle t0+386 for a period that starts in cycle t0.
- R4: In period cycle k (0..383), `coef_addr` equals k. The block uses the signed `coef_data` present in that same cycle as c[k]. With x[0] the newest sample, the unscaled sum is S = Σ c[k]·(x[k] + x[767-k]).
- R5: The period's samples are those accepted in cycles before its first cycle. Samples accepted during a period, at any rate up to one per cycle, do not change that period's result.
- R6: The sum is rounded by adding 2^(SHIFT-1) and then shifted arithmetically right by SHIFT (default 17).
- R7: A rounded value above 2^(OW-1)-1 is output as 2^(OW-1)-1. A value below -2^(OW-1) is output as -2^(OW-1).
- R8: `out_data` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| coef_addr | output | PW | Pair index into the half-length coefficient store |
| coef_data | input | CW | Signed coefficient for `coef_addr`, same cycle |
| out_valid | output | 1 | One-cycle strobe for a new output sample |
| out_data | output | OW | Signed, rounded and clamped output sample |

## Verification
A single impulse is fed through the whole 768-sample window. It lands in a different tap each period, so the output traces the coefficient sequence twice: once forwards and once mirrored. This reveals a swapped, reversed or misaligned read pointer.

A pseudo-random stream at the nominal one-in-twelve rate checks the general sum and the rounding.

Samples arriving on every clock push new writes right up against the oldest-sample read pointer. This separates a correct snapshot of the window from one that is corrupted by writes made during the period.

Full-scale constant inputs with maximum coefficients, one run positive and one negative, drive both clamp limits. The first output of each run must still be zero.

// File: rtl/sym_decim_fir.sv
module sym_decim_fir #(
  parameter int TAPS  = 768,
  parameter int DW    = 16,
  parameter int CW    = 18,
  parameter int OW    = 16,
  parameter int SHIFT = 17,
  localparam int HALF = TAPS / 2,
  localparam int AW   = $clog2(TAPS),
  localparam int PW   = $clog2(HALF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic        [PW-1:0] coef_addr,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int ACCW = DW + 1 + CW + PW;
  localparam logic [AW:0] TAPS_W = (AW+1)'(TAPS);
  localparam logic signed [ACCW:0] RND_C = (ACCW+1)'(1) <<< (SHIFT-1);
  localparam logic signed [ACCW:0] OMAX = (ACCW+1)'((1 <<< (OW-1)) - 1);
  localparam logic signed [ACCW:0] OMIN = ~OMAX;

  logic signed [DW-1:0] mem [TAPS];
  logic [AW-1:0] wr_ptr, base_q, base_now, rd_new, rd_old;
  logic [PW-1:0] phase;
  logic [AW:0]   old_sum, new_sum;

  assign coef_addr = phase;
  assign base_now  = (phase == '0) ? wr_ptr : base_q;
  assign old_sum   = {1'b0, base_now} + (AW+1)'(phase);
  assign new_sum   = {1'b0, base_now} + TAPS_W - (AW+1)'(1) - (AW+1)'(phase);
  assign rd_old    = (old_sum >= TAPS_W) ? AW'(old_sum - TAPS_W) : AW'(old_sum);
  assign rd_new    = (new_sum >= TAPS_W) ? AW'(new_sum - TAPS_W) : AW'(new_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
      wr_ptr <= '0;
    end else if (in_valid) begin
      mem[wr_ptr] <= in_data;
      wr_ptr <= (wr_ptr == AW'(TAPS-1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      base_q <= '0;
    end else begin
      phase  <= (phase == PW'(HALF-1)) ? '0 : phase + 1'b1;
      base_q <= base_now;
    end
  end

  logic signed [DW:0]     pre;
  logic signed [CW-1:0]   coef_q;
  logic                   s1_first, s1_last, done;
  logic signed [ACCW-1:0] acc, prod;
  logic signed [ACCW:0]   rnd;

  assign prod = ACCW'(pre) * ACCW'(coef_q);
  assign rnd  = ($signed({acc[ACCW-1], acc}) + RND_C) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0; coef_q <= '0; s1_first <= 1'b0; s1_last <= 1'b0;
      acc <= '0; done <= 1'b0; out_valid <= 1'b0; out_data <= '0;
    end else begin
      pre      <= (DW+1)'(mem[rd_new]) + (DW+1)'(mem[rd_old]);
      coef_q   <= coef_data;
      s1_first <= (phase == '0);
      s1_last  <= (phase == PW'(HALF-1));
      acc      <= s1_first ? prod : acc + prod;
      done     <= s1_last;
      out_valid <= done;
      if (done)
        out_data <= (rnd > OMAX) ? OW'(OMAX) : (rnd < OMIN) ? OW'(OMIN) : rnd[OW-1:0];
    end
  end

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> phase == PW'(2));
  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_new != rd_old && rd_new < AW'(TAPS) && rd_old < AW'(TAPS));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

// File: tb/test_sym_decim_fir.sv
`timescale 1ns/1ps
module test_sym_decim_fir;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [8:0] coef_addr;
  logic signed [17:0] coef_data;
  logic out_valid;
  logic signed [15:0] out_data;

  int compared = 0, mismatched = 0;
  int cyc = 0, coef_mode = 0, nh = 0;
  int hist [8192];
  int hw [8192];

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int coef(int k);
    if (coef_mode == 1) return 131071;
    return ((k * 53 + 17) % 211) - 105;
  endfunction

  always_comb coef_data = 18'(coef(int'(coef_addr)));

  sym_decim_fir i_sym_decim_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(out_valid), .out_data(out_data));

  function automatic longint xs(int j);
    return (j >= 0) ? longint'(hist[j]) : 0;
  endfunction

  function automatic int expected(int t0);
    int m = 0;
    longint s = 0;
    for (int i = 0; i < nh; i++) if (hw[i] < t0) m = i + 1;
    for (int k = 0; k < 384; k++)
      s += longint'(coef(k)) * (xs(m - 1 - k) + xs(m - 768 + k));
    s = (s + 65536) >>> 17;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  function automatic int sample(int kind, int i);
    case (kind)
      0: return (i == 0) ? 32767 : 0;
      1: return ((i * 7919 + 13) % 65536) - 32768;
      2: return 32767;
      default: return -32768;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; coef_mode = mode; nh = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic drive(int kind, int rate, int span);
    for (int c = 0; c < span; c++) begin
      @(negedge clk);
      if (c % rate == 0) begin
        in_valid = 1'b1;
        in_data = 16'(sample(kind, nh));
        hist[nh] = sample(kind, nh);
        hw[nh] = cyc;
        nh++;
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(string req, int nout);
    int got = 0, waited = 0, last = 0;
    bit prev = 1'b0;
    while (got < nout && waited < nout * 384 + 800) begin
      @(negedge clk);
      waited++;
      if (out_valid) begin
        check("R3 pulse width", int'(prev), 0);
        check("R3 period alignment", (cyc - 386) % 384, 0);
        check(req, int'(out_data), expected(cyc - 386));
        last = int'(out_data);
        got++;
      end else if (int'(out_data) != last) begin
        check("R8 hold between pulses", int'(out_data), last);
      end
      prev = out_valid;
    end
    check({req, " output count"}, got, nout);
  endtask

  task automatic t_reset_zero();
    do_reset(0);
    collect("R1 first output with empty buffer", 2);
  endtask

  task automatic t_impulse();
    do_reset(0);
    fork
      drive(0, 12, 26 * 384);
      collect("R4 impulse tap order and symmetry", 26);
    join
  endtask

  task automatic t_random();
    do_reset(0);
    fork
      drive(1, 12, 8 * 384);
      collect("R6 rounding of mixed stream", 8);
    join
  endtask

  task automatic t_every_cycle();
    do_reset(0);
    fork
      drive(1, 1, 6 * 384);
      collect("R5 snapshot under back-to-back writes", 6);
    join
  endtask

  task automatic t_saturate(int kind);
    do_reset(1);
    fork
      drive(kind, 1, 4 * 384);
      collect(kind == 2 ? "R7 clamp high" : "R7 clamp low", 4);
    join
  endtask

  initial begin
    t_reset_zero();
    t_impulse();
    t_random();
    t_every_cycle();
    t_saturate(2);
    t_saturate(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule